// File: doc/BRIEF.md
# Carry-Flag Arithmetic Unit with Borrow Semantics

This block is a single-cycle arithmetic unit of configurable width. It is built around one ripple adder and one carry flag register. Each clock edge it executes the opcode on its input and registers both the result and the new flag. Addition with or without the carry and subtraction with or without a borrow all use the same adder. A subtraction inverts the second operand and conditions the carry into and out of the adder, so the flag reads as a borrow after a subtraction. Three opcodes act on the flag alone: clear, set and toggle. An eighth code holds all state.

A mode input selects an early-processor style of subtraction. In that style, the plain subtract still takes its carry-in from the inverted flag, but it stores the adder's raw carry-out. A chain of such subtractions therefore needs a flag toggle between the steps. Multi-word arithmetic is done by feeding the words in, lowest first, and using the carry-aware opcodes after the first one.

Top module: `cfalu_core`

## Requirements
- R1: Opcode 0 (add with carry) registers {flag, result} = A + B + flag, taken as a W+1-bit sum.
- R2: Opcode 1 (add) registers {flag, result} = A + B. The old flag value has no effect.
- R3: Opcode 2 (subtract) with the mode input at 0 registers result = (A − B) mod 2^W. The flag becomes 1 exactly when A < B (borrow).
- R4: Opcode 3 (subtract with borrow) registers result = (A − B − flag) mod 2^W. The flag becomes 1 exactly when A < B + flag. This holds in both modes, so B = all ones with the flag set returns A with the borrow still set.
- R5: Opcodes 4, 5 and 6 set the flag to 0, set it to 1, and invert it, in that order. The registered result keeps its value for all three.
- R6: Opcode 7 leaves both the result and the flag unchanged, whatever the operands are.
- R7: With the mode input at 1, opcode 2 computes A + ~B + ~flag. The flag stores the raw carry-out, so 1 means no borrow. Every other opcode behaves as in R1 to R6.
- R8: Subtracting zero with opcode 2 in the normal mode returns A unchanged with the flag at 0, whatever the old flag value was.
- R9: A synchronous active-high reset clears the result and the flag at the next rising edge, and it takes priority over any opcode.
- R10: Results appear at the outputs after one rising edge. The width W is a parameter: at W = 16, subtracting 0x0503 from 0x1301 gives 0x0DFE with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Opcode: 0 adc, 1 add, 2 sub, 3 sbb, 4 clear, 5 set, 6 toggle, 7 hold |
| legacy_i | input | 1 | 1 selects the early-processor subtract flag behaviour |
| a_i | input | W | First operand (minuend for subtraction) |
| b_i | input | W | Second operand (subtrahend for subtraction) |
| res_o | output | W | Registered result |
| cf_o | output | 1 | Registered carry/borrow flag |

## Verification
All of this block's state is visible at its two outputs. A wrong flag therefore shows up on cf_o on the edge after the faulty operation. It also spreads into res_o one edge later, when the next carry-aware opcode adds one too many or one too few. A polarity error in the carry conditioning shows up most clearly in chained subtractions and in the subtract-zero case. For that reason the directed tests chain borrows across operations and compare the two modes on the same operands.

// File: rtl/cfalu_pkg.sv
package cfalu_pkg;

    typedef enum logic [2:0] {
        OP_ADC  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_CLC  = 3'd4,
        OP_STC  = 3'd5,
        OP_CMC  = 3'd6,
        OP_HOLD = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG,
        CIN_NFLAG
    } cin_e;

    typedef enum logic [2:0] {
        FL_ADDER,
        FL_ADDER_INV,
        FL_CLEAR,
        FL_SET,
        FL_TOGGLE,
        FL_KEEP
    } flag_e;

    typedef struct packed {
        logic  use_sum;
        logic  inv_b;
        cin_e  cin;
        flag_e flag;
    } ctrl_t;

endpackage

// File: rtl/cfalu_decode.sv
module cfalu_decode
    import cfalu_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       legacy_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '{use_sum: 1'b0, inv_b: 1'b0, cin: CIN_ZERO, flag: FL_KEEP};
        case (op_e'(op_i))
            OP_ADC: begin
                ctrl_o.use_sum = 1'b1;
                ctrl_o.cin     = CIN_FLAG;
                ctrl_o.flag    = FL_ADDER;
            end
            OP_ADD: begin
                ctrl_o.use_sum = 1'b1;
                ctrl_o.cin     = CIN_ZERO;
                ctrl_o.flag    = FL_ADDER;
            end
            OP_SUB: begin
                ctrl_o.use_sum = 1'b1;
                ctrl_o.inv_b   = 1'b1;
                ctrl_o.cin     = legacy_i ? CIN_NFLAG : CIN_ONE;
                ctrl_o.flag    = legacy_i ? FL_ADDER : FL_ADDER_INV;
            end
            OP_SBB: begin
                ctrl_o.use_sum = 1'b1;
                ctrl_o.inv_b   = 1'b1;
                ctrl_o.cin     = CIN_NFLAG;
                ctrl_o.flag    = FL_ADDER_INV;
            end
            OP_CLC:  ctrl_o.flag = FL_CLEAR;
            OP_STC:  ctrl_o.flag = FL_SET;
            OP_CMC:  ctrl_o.flag = FL_TOGGLE;
            default: ctrl_o.flag = FL_KEEP;
        endcase
    end

endmodule

// File: rtl/cfalu_adder.sv
module cfalu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]   = x_i[i] ^ y_i[i] ^ chain[i];
        assign chain[i+1] = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
    end

    assign cout_o = chain[W];

endmodule

// File: rtl/cfalu_core.sv
module cfalu_core
    import cfalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_i,
    input  logic         legacy_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         cf_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cf;
    } state_t;

    state_t       st_d, st_q;
    ctrl_t        ctrl;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         cin;
    logic         cout;

    cfalu_decode u_decode (
        .op_i     (op_i),
        .legacy_i (legacy_i),
        .ctrl_o   (ctrl)
    );

    // operand and carry conditioning in front of the shared adder
    always_comb begin
        b_eff = ctrl.inv_b ? ~b_i : b_i;
        case (ctrl.cin)
            CIN_ONE:   cin = 1'b1;
            CIN_FLAG:  cin = st_q.cf;
            CIN_NFLAG: cin = ~st_q.cf;
            default:   cin = 1'b0;
        endcase
    end

    cfalu_adder #(.W(W)) u_adder (
        .x_i    (a_i),
        .y_i    (b_eff),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl.use_sum) begin
            st_d.res = sum;
        end
        case (ctrl.flag)
            FL_ADDER:     st_d.cf = cout;
            FL_ADDER_INV: st_d.cf = ~cout;
            FL_CLEAR:     st_d.cf = 1'b0;
            FL_SET:       st_d.cf = 1'b1;
            FL_TOGGLE:    st_d.cf = ~st_q.cf;
            default:      st_d.cf = st_q.cf;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign cf_o  = st_q.cf;

endmodule

// File: rtl/cfalu_chk.sv
module cfalu_chk
    import cfalu_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_i,
    input logic         legacy_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] res_o,
    input logic         cf_o
);

    logic [W:0]   m_adc;
    logic [W:0]   m_add;
    logic [W-1:0] m_diff;
    logic [W-1:0] m_diffb;
    logic         m_lt;
    logic         m_ltb;

    always_comb begin
        m_adc   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cf_o};
        m_add   = {1'b0, a_i} + {1'b0, b_i};
        m_diff  = a_i - b_i;
        m_diffb = a_i - b_i - {{(W-1){1'b0}}, cf_o};
        m_lt    = a_i < b_i;
        m_ltb   = {1'b0, a_i} < ({1'b0, b_i} + {{W{1'b0}}, cf_o});
    end

    p_adc_sum_r1: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_ADC |=> {cf_o, res_o} == $past(m_adc));

    p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_ADD |=> {cf_o, res_o} == $past(m_add));

    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB && !legacy_i) |=> (res_o == $past(m_diff)) && (cf_o == $past(m_lt)));

    p_sbb_borrow_r4: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_SBB |=> (res_o == $past(m_diffb)) && (cf_o == $past(m_ltb)));

    p_flagop_keeps_res_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLC || op_i == OP_STC || op_i == OP_CMC) |=> $stable(res_o));

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CMC |=> cf_o != $past(cf_o));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_HOLD |=> $stable(res_o) && $stable(cf_o));

    p_legacy_raw_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB && legacy_i) |=> (res_o == $past(m_diffb)) && (cf_o == !$past(m_ltb)));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (res_o == '0) && !cf_o);

endmodule

bind cfalu_core cfalu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .legacy_i (legacy_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .res_o    (res_o),
    .cf_o     (cf_o)
);

// File: tb/cfalu_core_tb.sv
`timescale 1ns/1ps
module cfalu_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = 3'd7;
    logic        legacy = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic [7:0]  res;
    logic        cf;
    logic [15:0] res16;
    logic        cf16;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cfalu_core #(.W(8)) u_dut (
        .clk(clk), .rst(rst), .op_i(op), .legacy_i(legacy),
        .a_i(a), .b_i(b), .res_o(res), .cf_o(cf)
    );

    cfalu_core #(.W(16)) u_dut16 (
        .clk(clk), .rst(rst), .op_i(op), .legacy_i(legacy),
        .a_i(a16), .b_i(b16), .res_o(res16), .cf_o(cf16)
    );

    task automatic check(input string req, input logic [15:0] got_r, input logic [15:0] exp_r,
                         input logic got_c, input logic exp_c);
        checks++;
        if (got_r !== exp_r || got_c !== exp_c) begin
            errors++;
            $display("FAIL %s: got res=%h cf=%b, expected res=%h cf=%b", req, got_r, got_c, exp_r, exp_c);
        end
    endtask

    // inputs applied at a falling edge, outputs read at the following falling edge
    task automatic step(input logic [2:0] o, input logic lg, input logic [7:0] x, input logic [7:0] y);
        op = o; legacy = lg; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 reset state", {8'h0, res}, 16'h0, cf, 1'b0);
    endtask

    task automatic t_adc();
        step(3'd4, 0, 8'h00, 8'h00);
        step(3'd0, 0, 8'hF0, 8'h20);
        check("R1 adc carry out", {8'h0, res}, 16'h0010, cf, 1'b1);
        step(3'd0, 0, 8'h01, 8'h02);
        check("R1 adc carry in", {8'h0, res}, 16'h0004, cf, 1'b0);
    endtask

    task automatic t_add();
        step(3'd5, 0, 8'h00, 8'h00);
        step(3'd1, 0, 8'h05, 8'h09);
        check("R2 add ignores flag", {8'h0, res}, 16'h000E, cf, 1'b0);
        step(3'd1, 0, 8'hFF, 8'h01);
        check("R2 add wrap", {8'h0, res}, 16'h0000, cf, 1'b1);
    endtask

    task automatic t_sub_chain();
        step(3'd2, 0, 8'h01, 8'h03);
        check("R3 sub borrow", {8'h0, res}, 16'h00FE, cf, 1'b1);
        step(3'd3, 0, 8'h13, 8'h05);
        check("R4 sbb chained", {8'h0, res}, 16'h000D, cf, 1'b0);
    endtask

    task automatic t_sbb_cases();
        step(3'd4, 0, 8'h00, 8'h00);
        step(3'd3, 0, 8'h20, 8'h01);
        check("R4 sbb no borrow in", {8'h0, res}, 16'h001F, cf, 1'b0);
        step(3'd5, 0, 8'h00, 8'h00);
        step(3'd3, 0, 8'h0A, 8'hFF);
        check("R4 sbb borrow propagate", {8'h0, res}, 16'h000A, cf, 1'b1);
    endtask

    task automatic t_zero();
        step(3'd5, 0, 8'h00, 8'h00);
        step(3'd2, 0, 8'h5A, 8'h00);
        check("R8 subtract zero flag set", {8'h0, res}, 16'h005A, cf, 1'b0);
        step(3'd2, 0, 8'h00, 8'h00);
        check("R8 subtract zero from zero", {8'h0, res}, 16'h0000, cf, 1'b0);
    endtask

    task automatic t_flagops();
        step(3'd1, 0, 8'h33, 8'h11);
        step(3'd5, 0, 8'hAA, 8'hAA);
        check("R5 set", {8'h0, res}, 16'h0044, cf, 1'b1);
        step(3'd6, 0, 8'h01, 8'h02);
        check("R5 toggle to 0", {8'h0, res}, 16'h0044, cf, 1'b0);
        step(3'd6, 0, 8'h03, 8'h04);
        check("R5 toggle to 1", {8'h0, res}, 16'h0044, cf, 1'b1);
        step(3'd4, 0, 8'hFF, 8'hFF);
        check("R5 clear", {8'h0, res}, 16'h0044, cf, 1'b0);
    endtask

    task automatic t_hold();
        step(3'd1, 0, 8'h10, 8'h20);
        step(3'd5, 0, 8'h00, 8'h00);
        step(3'd7, 0, 8'hFF, 8'hFF);
        check("R6 hold", {8'h0, res}, 16'h0030, cf, 1'b1);
        step(3'd7, 1, 8'h80, 8'h01);
        check("R6 hold again", {8'h0, res}, 16'h0030, cf, 1'b1);
    endtask

    task automatic t_legacy();
        step(3'd4, 1, 8'h00, 8'h00);
        step(3'd2, 1, 8'h01, 8'h03);
        check("R7 legacy sub raw carry", {8'h0, res}, 16'h00FE, cf, 1'b0);
        step(3'd6, 1, 8'h00, 8'h00);
        step(3'd2, 1, 8'h13, 8'h05);
        check("R7 legacy sub after toggle", {8'h0, res}, 16'h000D, cf, 1'b1);
        step(3'd3, 1, 8'h13, 8'h05);
        check("R7 legacy leaves sbb", {8'h0, res}, 16'h000D, cf, 1'b0);
        step(3'd1, 1, 8'h80, 8'h80);
        check("R7 legacy leaves add", {8'h0, res}, 16'h0000, cf, 1'b1);
    endtask

    task automatic t_wide();
        a16 = 16'h1301; b16 = 16'h0503;
        step(3'd2, 0, 8'h01, 8'h01);
        check("R10 wide sub", res16, 16'h0DFE, cf16, 1'b0);
        check("R10 narrow same step", {8'h0, res}, 16'h0000, cf, 1'b0);
    endtask

    task automatic t_reset_mid();
        step(3'd5, 0, 8'h00, 8'h00);
        rst = 1'b1;
        step(3'd5, 0, 8'h00, 8'h00);
        rst = 1'b0;
        check("R9 reset over set", {8'h0, res}, 16'h0000, cf, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_adc();
        t_add();
        t_sub_chain();
        t_sbb_cases();
        t_zero();
        t_flagops();
        t_hold();
        t_legacy();
        t_wide();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule